// File: doc/BRIEF.md
# LCD Pixel Clock Phase Selector

This block sits at the edge of a parallel RGB panel interface. It takes a fast source clock and derives from it the pixel clock that leaves the chip, together with registered copies of the pixel word and of the three timing strobes (horizontal sync, vertical sync, data enable). A 3-bit phase code chooses where the exported clock edge sits relative to the point where data is launched. It offers normal phase, a delay of one third or two thirds of a pixel period, or one of two half-rate clocks offset by 0 or 90 degrees. Separate polarity bits make each strobe active-high or active-low. The pixel bits themselves are never inverted.

Time is counted in slots, one slot per source clock cycle. An output period is a frame of slots numbered from 0. In the one-third modes a frame has 3 slots, with one pixel launched per frame (the source runs at 3x the pixel rate). In the half-rate modes a frame has 4 slots, with a pixel launched in slot 0 and in slot 2. The exported clock then runs at half the pixel rate, and a 90-degree shift is exactly one slot. Slot k is the state after the k-th rising source edge of a frame. All outputs are registered, so every pin changes on the edge that enters a slot. The first rising edge after reset is released enters slot 0.

Top module: `lcd_pclk_phase`

## Requirements
- R1: With phase code 0 the frame is 3 slots long and the pixel clock is high in slots 0 and 1 and low in slot 2. Its rising edge coincides with the data launch in slot 0.
- R2: Code 1 gives a 3-slot frame with the clock high in slots 1 and 2. Code 2 gives a 3-slot frame with the clock high in slots 2 and 0. Data is still launched in slot 0 for both.
- R3: Code 5 (half rate, 0 degrees) gives a 4-slot frame with the clock high in slots 0 and 1. A pixel is launched in slots 0 and 2, so the clock runs at half the pixel rate.
- R4: Code 4 (half rate, 90 degrees) gives a 4-slot frame with the clock high in slots 1 and 2, one slot after code 5. Launches fall in slots 0 and 2.
- R5: Codes 3, 6 and 7 behave exactly like code 0.
- R6: A new phase code is sampled only on the edge that starts a new frame (slot 0). A change made in the middle of a frame leaves the rest of that frame unchanged.
- R7: The polarity bits are ordered bit 0 horizontal sync, bit 1 vertical sync, bit 2 data enable. The strobe inputs are active-high. A polarity bit of 0 drives the matching output as the inverse of its input (an active-low pulse). A bit of 1 passes the input through unchanged.
- R8: The pixel word is never inverted by the polarity bits. The pixel word and the strobes are captured only on launch edges and hold their values in all other slots.
- R9: While reset is high at a rising edge, that edge drives the pixel clock low, drives the pixel word to 0, and drives each strobe to its inactive level (the inverse of its polarity bit).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast source clock |
| rst_i | input | 1 | Synchronous active-high reset |
| phase_sel_i | input | 3 | Phase code |
| pol_i | input | 3 | Strobe polarity: bit 0 hsync, 1 vsync, 2 data enable; 1 = active-high |
| hs_i | input | 1 | Raw horizontal sync, active-high |
| vs_i | input | 1 | Raw vertical sync, active-high |
| de_i | input | 1 | Raw data enable, active-high |
| pix_i | input | DATA_W | Pixel word to launch |
| pclk_o | output | 1 | Exported pixel clock |
| hs_o | output | 1 | Horizontal sync after polarity |
| vs_o | output | 1 | Vertical sync after polarity |
| de_o | output | 1 | Data enable after polarity |
| pix_o | output | DATA_W | Registered pixel word |

## Verification
If the slot counter or the held mode is wrong, the clock pattern is off within one frame: 3 or 4 source cycles after reset or after a code change. It shows up either as a high level in the wrong slot or as a launch edge that no longer lines up with the rising clock edge. If the capture enable is wrong, the pixel word or a strobe changes in a slot where it must hold. That is visible on the very next edge. A late or early code change shows up as a clock level in the remaining slots of the frame that belongs to the new code instead of the old one.

// File: rtl/lcdp_pkg.sv
package lcdp_pkg;

  localparam int SLOT_W = 2;
  typedef logic [SLOT_W-1:0] slot_t;

  typedef enum logic [2:0] {
    PM_NORM   = 3'd0,
    PM_THIRD1 = 3'd1,
    PM_THIRD2 = 3'd2,
    PM_HALF0  = 3'd3,
    PM_HALF90 = 3'd4
  } phase_mode_e;

  // Map the external phase code to an internal mode; unused codes fall to normal.
  function automatic phase_mode_e decode_code(input logic [2:0] code);
    phase_mode_e m;
    case (code)
      3'd1:    m = PM_THIRD1;
      3'd2:    m = PM_THIRD2;
      3'd4:    m = PM_HALF90;
      3'd5:    m = PM_HALF0;
      default: m = PM_NORM;
    endcase
    return m;
  endfunction

  function automatic logic is_half(input phase_mode_e m);
    return (m == PM_HALF0) || (m == PM_HALF90);
  endfunction

  // Index of the final slot of a frame.
  function automatic slot_t last_slot(input phase_mode_e m);
    return is_half(m) ? slot_t'(3) : slot_t'(2);
  endfunction

  // Level of the exported clock in a given slot.
  function automatic logic clk_level(input phase_mode_e m, input slot_t s);
    logic lv;
    case (m)
      PM_THIRD1: lv = (s == slot_t'(1)) || (s == slot_t'(2));
      PM_THIRD2: lv = (s == slot_t'(2)) || (s == slot_t'(0));
      PM_HALF90: lv = (s == slot_t'(1)) || (s == slot_t'(2));
      default:   lv = (s == slot_t'(0)) || (s == slot_t'(1));
    endcase
    return lv;
  endfunction

  // Slots in which a pixel and its strobes are captured.
  function automatic logic is_launch(input phase_mode_e m, input slot_t s);
    return (s == slot_t'(0)) || (is_half(m) && (s == slot_t'(2)));
  endfunction

endpackage

// File: rtl/lcdp_slot_seq.sv
module lcdp_slot_seq
  import lcdp_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_i,
  input  logic [2:0]  code_i,
  output slot_t       nxt_slot_o,
  output phase_mode_e nxt_mode_o
);

  slot_t       slot_q;
  phase_mode_e mode_q;
  logic        wrap;
  logic        rst_q;

  always_comb begin
    wrap       = (slot_q == last_slot(mode_q));
    nxt_slot_o = wrap ? slot_t'(0) : slot_q + slot_t'(1);
    nxt_mode_o = wrap ? decode_code(code_i) : mode_q;
  end

  always_ff @(posedge clk_i) begin
    rst_q <= rst_i;
    if (rst_i) begin
      slot_q <= last_slot(PM_NORM);
      mode_q <= PM_NORM;
    end else begin
      slot_q <= nxt_slot_o;
      mode_q <= nxt_mode_o;
    end
  end

  // R6
  mode_at_frame_start_chk: assert property (@(posedge clk_i) disable iff (rst_i || rst_q)
    (mode_q != $past(mode_q)) |-> (slot_q == slot_t'(0)));

  // R1
  third_frame_len_chk: assert property (@(posedge clk_i) disable iff (rst_i || rst_q)
    !is_half(mode_q) |-> (slot_q != slot_t'(3)));

endmodule

// File: rtl/lcdp_clk_shaper.sv
module lcdp_clk_shaper
  import lcdp_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_i,
  input  slot_t       nxt_slot_i,
  input  phase_mode_e nxt_mode_i,
  output logic        pclk_o
);

  logic pclk_q;
  logic rst_q;

  always_ff @(posedge clk_i) begin
    rst_q <= rst_i;
    if (rst_i) pclk_q <= 1'b0;
    else       pclk_q <= clk_level(nxt_mode_i, nxt_slot_i);
  end

  assign pclk_o = pclk_q;

  // R9
  clk_low_in_reset_chk: assert property (@(posedge clk_i)
    rst_q |-> !pclk_q);

endmodule

// File: rtl/lcdp_launch.sv
module lcdp_launch #(
  parameter int DATA_W = 24,
  parameter int CTL_N  = 3
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              launch_i,
  input  logic [CTL_N-1:0]  pol_i,
  input  logic [CTL_N-1:0]  ctl_i,
  input  logic [DATA_W-1:0] pix_i,
  output logic [CTL_N-1:0]  ctl_o,
  output logic [DATA_W-1:0] pix_o
);

  logic [CTL_N-1:0]  ctl_q;
  logic [DATA_W-1:0] pix_q;
  logic              rst_q;

  always_ff @(posedge clk_i) begin
    rst_q <= rst_i;
    if (rst_i) begin
      pix_q <= '0;
      for (int i = 0; i < CTL_N; i++) ctl_q[i] <= ~pol_i[i];
    end else if (launch_i) begin
      pix_q <= pix_i;
      for (int i = 0; i < CTL_N; i++) ctl_q[i] <= ctl_i[i] ^ ~pol_i[i];
    end
  end

  assign ctl_o = ctl_q;
  assign pix_o = pix_q;

  // R9
  strobes_idle_in_reset_chk: assert property (@(posedge clk_i)
    rst_q |-> (ctl_q == ~$past(pol_i)));

  // R8
  pix_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i || rst_q)
    !$past(launch_i) |-> $stable(pix_q));

  // R8
  ctl_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i || rst_q)
    !$past(launch_i) |-> $stable(ctl_q));

endmodule

// File: rtl/lcd_pclk_phase.sv
module lcd_pclk_phase
  import lcdp_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [2:0]        phase_sel_i,
  input  logic [2:0]        pol_i,
  input  logic              hs_i,
  input  logic              vs_i,
  input  logic              de_i,
  input  logic [DATA_W-1:0] pix_i,
  output logic              pclk_o,
  output logic              hs_o,
  output logic              vs_o,
  output logic              de_o,
  output logic [DATA_W-1:0] pix_o
);

  localparam int CTL_N = 3;

  slot_t            nxt_slot;
  phase_mode_e      nxt_mode;
  logic             launch;
  logic [CTL_N-1:0] ctl_out;

  lcdp_slot_seq u_seq (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .code_i     (phase_sel_i),
    .nxt_slot_o (nxt_slot),
    .nxt_mode_o (nxt_mode)
  );

  lcdp_clk_shaper u_shaper (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .nxt_slot_i (nxt_slot),
    .nxt_mode_i (nxt_mode),
    .pclk_o     (pclk_o)
  );

  assign launch = is_launch(nxt_mode, nxt_slot);

  lcdp_launch #(.DATA_W(DATA_W), .CTL_N(CTL_N)) u_launch (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .launch_i (launch),
    .pol_i    (pol_i),
    .ctl_i    ({de_i, vs_i, hs_i}),
    .pix_i    (pix_i),
    .ctl_o    (ctl_out),
    .pix_o    (pix_o)
  );

  assign hs_o = ctl_out[0];
  assign vs_o = ctl_out[1];
  assign de_o = ctl_out[2];

endmodule

// File: tb/lcd_pclk_phase_bench.sv
module lcd_pclk_phase_bench;

  localparam int DATA_W = 24;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [2:0]        sel = 3'd0;
  logic [2:0]        pol = 3'd0;
  logic              hs = 1'b0, vs = 1'b0, de = 1'b0;
  logic [DATA_W-1:0] pix = '0;
  logic              pclk, hs_o, vs_o, de_o;
  logic [DATA_W-1:0] pix_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lcd_pclk_phase #(.DATA_W(DATA_W)) u_lcd_pclk_phase (
    .clk_i(clk), .rst_i(rst), .phase_sel_i(sel), .pol_i(pol),
    .hs_i(hs), .vs_i(vs), .de_i(de), .pix_i(pix),
    .pclk_o(pclk), .hs_o(hs_o), .vs_o(vs_o), .de_o(de_o), .pix_o(pix_o)
  );

  // {code, frame length, high-slot mask, launch-slot mask}
  localparam logic [13:0] VEC [8] = '{
    {3'd0, 3'd3, 4'b0011, 4'b0001},   // R1
    {3'd1, 3'd3, 4'b0110, 4'b0001},   // R2
    {3'd2, 3'd3, 4'b0101, 4'b0001},   // R2
    {3'd3, 3'd3, 4'b0011, 4'b0001},   // R5
    {3'd4, 3'd4, 4'b0110, 4'b0101},   // R4
    {3'd5, 3'd4, 4'b0011, 4'b0101},   // R3
    {3'd6, 3'd3, 4'b0011, 4'b0001},   // R5
    {3'd7, 3'd3, 4'b0011, 4'b0001}    // R5
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // Hold reset over two edges, release at a falling edge.
  task automatic do_reset(input logic [2:0] code, input logic [2:0] p);
    @(negedge clk);
    rst = 1'b1; sel = code; pol = p;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=timeout exp=finish");
    finish_run();
  end

  initial begin
    // R9: reset state, polarity 000 then 101
    do_reset(3'd0, 3'b000);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R9 pclk", {31'd0, pclk}, 32'd0);
    chk("R9 strobes pol000", {29'd0, de_o, vs_o, hs_o}, 32'b111);
    chk("R9 pix", {8'd0, pix_o}, 32'd0);
    pol = 3'b101;
    @(posedge clk); @(negedge clk);
    chk("R9 strobes pol101", {29'd0, de_o, vs_o, hs_o}, 32'b010);

    // Vector walk: R1 R2 R3 R4 R5 R8
    for (int v = 0; v < 8; v++) begin
      logic [2:0] code, len;
      logic [3:0] hi, ln;
      logic [DATA_W-1:0] exp_pix;
      {code, len, hi, ln} = VEC[v];
      do_reset(code, 3'b111);
      exp_pix = '0;
      for (int k = 0; k < 8; k++) begin
        int s;
        s = k % int'(len);
        pix = DATA_W'(32'h00A50000 + v * 16 + k);
        @(posedge clk); @(negedge clk);
        if (ln[s]) exp_pix = DATA_W'(32'h00A50000 + v * 16 + k);
        chk($sformatf("R1-5 code%0d slot%0d pclk", code, s), {31'd0, pclk}, {31'd0, hi[s]});
        chk($sformatf("R8 code%0d slot%0d pix", code, s), {8'd0, pix_o}, {8'd0, exp_pix});
      end
    end

    // R7 / R8: polarity 000 inverts strobes, not data
    do_reset(3'd0, 3'b000);
    hs = 1'b1; vs = 1'b0; de = 1'b1; pix = 24'hF0F00F;
    @(posedge clk); @(negedge clk);
    chk("R7 active-low strobes", {29'd0, de_o, vs_o, hs_o}, 32'b010);
    chk("R8 pix not inverted", {8'd0, pix_o}, 32'h00F0F00F);
    pol = 3'b111; pix = 24'h123456;
    @(posedge clk); @(negedge clk);
    chk("R8 strobes hold off-launch", {29'd0, de_o, vs_o, hs_o}, 32'b010);
    chk("R8 pix hold off-launch", {8'd0, pix_o}, 32'h00F0F00F);
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    chk("R7 active-high strobes", {29'd0, de_o, vs_o, hs_o}, 32'b101);
    chk("R8 pix launch", {8'd0, pix_o}, 32'h00123456);

    // R6: code change mid-frame waits for the next frame
    do_reset(3'd0, 3'b111);
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    sel = 3'd1;
    @(posedge clk); @(negedge clk);
    chk("R6 slot2 keeps old code", {31'd0, pclk}, 32'd0);
    @(posedge clk); @(negedge clk);
    chk("R6 new frame slot0", {31'd0, pclk}, 32'd0);
    @(posedge clk); @(negedge clk);
    chk("R6 new frame slot1", {31'd0, pclk}, 32'd1);
    @(posedge clk); @(negedge clk);
    chk("R6 new frame slot2", {31'd0, pclk}, 32'd1);

    // R3 after R6: switch to half rate, frame grows to 4 slots
    sel = 3'd5;
    for (int k = 0; k < 8; k++) begin
      @(posedge clk); @(negedge clk);
      chk($sformatf("R3 switched slot%0d", k % 4), {31'd0, pclk}, {31'd0, (k % 4) < 2});
    end

    finish_run();
  end

endmodule